// File: doc/BRIEF.md
# Multi-Mode Serial Flash Read Sequencer

This block runs one read transaction against a serial NOR flash and returns one byte. A single start pulse, standing in for a command bit that clears itself, latches the configuration and pulls chip select low. The sequencer then shifts out an 8-bit opcode on one line, followed by a 3- or 4-byte address on one, two or four lines. It idles the bus for the dummy cycles that the chosen read form needs and collects one data byte on one, two or four lines. When the byte lands in the read-data register, chip select goes high and the busy flag drops in the same cycle.

A five-bit bus-mode word selects the read form: single line (normal or fast), dual data, dual address plus data, quad data, or quad address plus data. Each form has a fixed dummy-cycle count and takes its opcode from its own source input. The data pins are split into output, output-enable and input vectors, and the pad cells sit outside the block. The block drives the pins only while the opcode and the address go out.

Top module: `sflash_read_seq`

## Requirements
- R1: After reset, and whenever no read is in progress, cs_n_o is 1, sck_o is 0, io_oe_o is 4'b0000 and busy_o is 0.
- R2: A start pulse while idle sets busy_o and clears cs_n_o on the next clock edge. The configuration, address and opcodes are captured at that edge. A start pulse while busy_o is 1 is ignored, and the read in progress runs to completion unchanged.
- R3: sck_o idles low and has a period of 2*SCK_HALF clock cycles while busy (2 with the default). Outputs change while sck_o is low and are stable at its rising edge. Input data is sampled at the end of the high half.
- R4: The opcode is sent as 8 bits, MSB first, on io_o[0] with io_oe_o = 4'b0001, in every mode.
- R5: The opcode comes from opc_quad_i in the two quad forms, from opc_dual_i in the two dual forms, and from opc_single_i otherwise.
- R6: The address is 24 bits (addr_i[23:0]) or 32 bits when bus_mode_i[4] is 1, sent MSB first. It uses one line (io_oe_o 4'b0001) by default, two lines io[1:0] with io[1] carrying the higher bit (4'b0011) when the dual-address form is selected, and four lines (4'b1111, MSB of each nibble on io[3]) in the quad-address form.
- R7: The number of dummy SCK cycles is 0 for the single-line form with fast_rd_i = 0 and 8 with fast_rd_i = 1. It is 8 for dual or quad data with a one-line address, 4 for the dual-address form and 6 for the quad-address form. fast_rd_i has no effect outside the single-line form.
- R8: io_oe_o is 4'b0000 from the first dummy cycle to the end of the read.
- R9: Data is received MSB first: one bit per SCK on io_i[1] in single form, two bits on io_i[1:0] (io_i[1] higher) in dual forms, and four bits on io_i[3:0] (io_i[3] highest) in quad forms.
- R10: In the cycle busy_o falls, cs_n_o is 1, sck_o is 0 and rd_data_o holds the received byte.
- R11: bus_mode_i[3:0] decodes as 4'b0001 dual data, 4'b0011 dual address and data, 4'b0100 quad data, 4'b1100 quad address and data, and 4'b0000 single. Every other value of bus_mode_i[3:0] gives the single-line form, with opcode source and dummy count as in 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for one read |
| fast_rd_i | input | 1 | Fast-read select for the single-line form |
| bus_mode_i | input | 5 | Mode bits: [0] dual data, [1] dual address, [2] quad data, [3] quad address, [4] four-byte address |
| addr_i | input | 32 | Address, byte 0 least significant |
| opc_single_i | input | 8 | Opcode for the single-line form |
| opc_dual_i | input | 8 | Opcode for the dual forms |
| opc_quad_i | input | 8 | Opcode for the quad forms |
| io_i | input | 4 | Flash data pins, input side |
| busy_o | output | 1 | Read in progress (self-clearing command bit) |
| rd_data_o | output | 8 | Last received byte |
| cs_n_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock |
| io_o | output | 4 | Flash data pins, output side |
| io_oe_o | output | 4 | Output enable per data pin |

## Verification
On every cycle, the assertions check that the pins stay quiet while chip select is high, that a launch raises busy and lowers chip select, that the enable vector takes only a legal lane shape, that SCK toggles on each cycle while busy, and that the end of a read leaves chip select high with SCK low. Other properties need a flash model on the pins, and only the bench's scenarios can show them. These are the bit order and lane mapping of opcode, address and data, the dummy count of each mode, the opcode source, the fallback of illegal mode values, and a start pulse mid-read having no effect. The bench sweeps all 32 mode words with both fast-read settings and predicts each transaction from the mode arithmetic.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

   localparam int DUMMY_W = 5;

   typedef enum logic [1:0] {
      LN_1 = 2'd0,
      LN_2 = 2'd1,
      LN_4 = 2'd2
   } lane_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_ADDR,
      ST_DUMMY,
      ST_DATA
   } seq_st_e;

   typedef struct packed {
      lane_e              addr_ln;
      lane_e              data_ln;
      logic [DUMMY_W-1:0] dummy;
      logic               four_byte;
   } rd_cfg_t;

   // log2 of the lane count
   function automatic int lane_sh(lane_e l);
      case (l)
         LN_2:    return 1;
         LN_4:    return 2;
         default: return 0;
      endcase
   endfunction

   function automatic logic [3:0] lane_mask(lane_e l);
      case (l)
         LN_2:    return 4'b0011;
         LN_4:    return 4'b1111;
         default: return 4'b0001;
      endcase
   endfunction

endpackage

// File: rtl/sfr_mode_dec.sv
module sfr_mode_dec
   import sfr_pkg::*;
#(
   parameter int DUMMY_FAST = 8,
   parameter int DUMMY_WIDE = 8,
   parameter int DUMMY_DIO  = 4,
   parameter int DUMMY_QIO  = 6
) (
   input  logic [4:0] mode_i,
   input  logic       fast_i,
   output rd_cfg_t    cfg_o
);

   localparam int DMAX = (1 << DUMMY_W) - 1;

   if (DUMMY_FAST > DMAX || DUMMY_WIDE > DMAX || DUMMY_DIO > DMAX || DUMMY_QIO > DMAX) begin : g_bad_dummy
      $error("dummy count does not fit the dummy field");
   end

   always_comb begin
      cfg_o           = '0;
      cfg_o.four_byte = mode_i[4];
      cfg_o.addr_ln   = LN_1;
      cfg_o.data_ln   = LN_1;
      case (mode_i[3:0])
         4'b0001: begin
            cfg_o.data_ln = LN_2;
            cfg_o.dummy   = DUMMY_W'(DUMMY_WIDE);
         end
         4'b0011: begin
            cfg_o.data_ln = LN_2;
            cfg_o.addr_ln = LN_2;
            cfg_o.dummy   = DUMMY_W'(DUMMY_DIO);
         end
         4'b0100: begin
            cfg_o.data_ln = LN_4;
            cfg_o.dummy   = DUMMY_W'(DUMMY_WIDE);
         end
         4'b1100: begin
            cfg_o.data_ln = LN_4;
            cfg_o.addr_ln = LN_4;
            cfg_o.dummy   = DUMMY_W'(DUMMY_QIO);
         end
         default: begin
            // single-line form, including every illegal combination
            cfg_o.dummy = fast_i ? DUMMY_W'(DUMMY_FAST) : '0;
         end
      endcase
   end

endmodule

// File: rtl/sfr_tx_shift.sv
module sfr_tx_shift
   import sfr_pkg::*;
#(
   parameter int W = 40
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         shift_i,
   input  lane_e        amt_i,
   output logic [3:0]   top_o
);

   if (W < 4) begin : g_bad_w
      $error("shift register narrower than one nibble");
   end

   logic [W-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (load_i) begin
         sr_q <= load_val_i;
      end else if (shift_i) begin
         case (amt_i)
            LN_2:    sr_q <= {sr_q[W-3:0], 2'b00};
            LN_4:    sr_q <= {sr_q[W-5:0], 4'b0000};
            default: sr_q <= {sr_q[W-2:0], 1'b0};
         endcase
      end
   end

   assign top_o = sr_q[W-1 -: 4];

endmodule

// File: rtl/sfr_rx_shift.sv
module sfr_rx_shift
   import sfr_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         shift_i,
   input  lane_e        ln_i,
   input  logic [3:0]   io_i,
   output logic [W-1:0] nxt_o
);

   if (W < 4 || (W % 4) != 0) begin : g_bad_w
      $error("receive width must be a multiple of four");
   end

   logic [W-1:0] cur_q;

   always_comb begin
      case (ln_i)
         LN_2:    nxt_o = {cur_q[W-3:0], io_i[1:0]};
         LN_4:    nxt_o = {cur_q[W-5:0], io_i};
         default: nxt_o = {cur_q[W-2:0], io_i[1]};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cur_q <= '0;
      else if (clr_i)   cur_q <= '0;
      else if (shift_i) cur_q <= nxt_o;
   end

endmodule

// File: rtl/sflash_read_seq.sv
module sflash_read_seq
   import sfr_pkg::*;
#(
   parameter int SCK_HALF   = 1,
   parameter int DUMMY_FAST = 8,
   parameter int DUMMY_WIDE = 8,
   parameter int DUMMY_DIO  = 4,
   parameter int DUMMY_QIO  = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       fast_rd_i,
   input  logic [4:0] bus_mode_i,
   input  logic [31:0] addr_i,
   input  logic [7:0] opc_single_i,
   input  logic [7:0] opc_dual_i,
   input  logic [7:0] opc_quad_i,
   input  logic [3:0] io_i,
   output logic       busy_o,
   output logic [7:0] rd_data_o,
   output logic       cs_n_o,
   output logic       sck_o,
   output logic [3:0] io_o,
   output logic [3:0] io_oe_o
);

   localparam int OP_W   = 8;
   localparam int ADR_W  = 32;
   localparam int TX_W   = OP_W + ADR_W;
   localparam int BYTE_W = 8;
   localparam int CNT_W  = $clog2(ADR_W + 1);
   localparam int DIV_W  = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

   if (SCK_HALF < 1) begin : g_bad_half
      $error("SCK_HALF must be at least one");
   end

   rd_cfg_t    cfg_d, cfg_q;
   seq_st_e    st_q;
   logic       ph_q, cs_q, busy_q, tick;
   logic [CNT_W-1:0] cnt_q;
   logic [BYTE_W-1:0] rd_q, rx_nxt;
   logic [OP_W-1:0]   op_sel;
   logic [TX_W-1:0]   load_val;
   logic [3:0]        tx_top;
   logic              launch, edge_hi, tx_shift, rx_shift;
   lane_e             tx_amt;

   sfr_mode_dec #(
      .DUMMY_FAST (DUMMY_FAST),
      .DUMMY_WIDE (DUMMY_WIDE),
      .DUMMY_DIO  (DUMMY_DIO),
      .DUMMY_QIO  (DUMMY_QIO)
   ) u_dec (
      .mode_i (bus_mode_i),
      .fast_i (fast_rd_i),
      .cfg_o  (cfg_d)
   );

   // opcode source follows the data lane count of the decoded form
   always_comb begin
      case (cfg_d.data_ln)
         LN_4:    op_sel = opc_quad_i;
         LN_2:    op_sel = opc_dual_i;
         default: op_sel = opc_single_i;
      endcase
   end

   assign load_val = {op_sel, cfg_d.four_byte ? addr_i : {addr_i[23:0], 8'h00}};
   assign launch   = start_i && !busy_q;
   assign edge_hi  = busy_q && tick && ph_q;
   assign tx_shift = edge_hi && (st_q == ST_CMD || st_q == ST_ADDR);
   assign rx_shift = edge_hi && (st_q == ST_DATA);
   assign tx_amt   = (st_q == ST_CMD) ? LN_1 : cfg_q.addr_ln;

   sfr_tx_shift #(.W(TX_W)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (launch),
      .load_val_i (load_val),
      .shift_i    (tx_shift),
      .amt_i      (tx_amt),
      .top_o      (tx_top)
   );

   sfr_rx_shift #(.W(BYTE_W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (launch),
      .shift_i (rx_shift),
      .ln_i    (cfg_q.data_ln),
      .io_i    (io_i),
      .nxt_o   (rx_nxt)
   );

   // half-period pacing of SCK
   if (SCK_HALF == 1) begin : g_nodiv
      assign tick = 1'b1;
   end else begin : g_div
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         div_q <= '0;
         else if (launch || !busy_q)         div_q <= '0;
         else if (div_q == DIV_W'(SCK_HALF - 1)) div_q <= '0;
         else                                div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == DIV_W'(SCK_HALF - 1));
   end

   function automatic logic [CNT_W-1:0] addr_cycles(rd_cfg_t c);
      int bits;
      bits = c.four_byte ? ADR_W : 24;
      return CNT_W'((bits >> lane_sh(c.addr_ln)) - 1);
   endfunction

   function automatic logic [CNT_W-1:0] data_cycles(rd_cfg_t c);
      return CNT_W'((BYTE_W >> lane_sh(c.data_ln)) - 1);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cfg_q  <= '0;
         cnt_q  <= '0;
         ph_q   <= 1'b0;
         cs_q   <= 1'b1;
         busy_q <= 1'b0;
         rd_q   <= '0;
      end else if (launch) begin
         cfg_q  <= cfg_d;
         st_q   <= ST_CMD;
         cnt_q  <= CNT_W'(OP_W - 1);
         ph_q   <= 1'b0;
         cs_q   <= 1'b0;
         busy_q <= 1'b1;
      end else if (busy_q && tick) begin
         ph_q <= !ph_q;
         if (ph_q) begin
            if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end else begin
               case (st_q)
                  ST_CMD: begin
                     st_q  <= ST_ADDR;
                     cnt_q <= addr_cycles(cfg_q);
                  end
                  ST_ADDR: begin
                     if (cfg_q.dummy == '0) begin
                        st_q  <= ST_DATA;
                        cnt_q <= data_cycles(cfg_q);
                     end else begin
                        st_q  <= ST_DUMMY;
                        cnt_q <= CNT_W'(cfg_q.dummy) - 1'b1;
                     end
                  end
                  ST_DUMMY: begin
                     st_q  <= ST_DATA;
                     cnt_q <= data_cycles(cfg_q);
                  end
                  default: begin
                     st_q   <= ST_IDLE;
                     cs_q   <= 1'b1;
                     busy_q <= 1'b0;
                     rd_q   <= rx_nxt;
                  end
               endcase
            end
         end
      end
   end

   always_comb begin
      io_o    = 4'b0000;
      io_oe_o = 4'b0000;
      case (st_q)
         ST_CMD: begin
            io_o    = {3'b000, tx_top[3]};
            io_oe_o = 4'b0001;
         end
         ST_ADDR: begin
            io_oe_o = lane_mask(cfg_q.addr_ln);
            case (cfg_q.addr_ln)
               LN_2:    io_o = {2'b00, tx_top[3:2]};
               LN_4:    io_o = tx_top;
               default: io_o = {3'b000, tx_top[3]};
            endcase
         end
         default: ;
      endcase
   end

   assign busy_o    = busy_q;
   assign cs_n_o    = cs_q;
   assign sck_o     = ph_q;
   assign rd_data_o = rd_q;

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> (!sck_o && io_oe_o == 4'b0000));

   // R2
   launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && !cs_n_o));

   // R6
   oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      io_oe_o inside {4'b0000, 4'b0001, 4'b0011, 4'b1111});

   // R8
   dummy_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DUMMY || st_q == ST_DATA) |-> (io_oe_o == 4'b0000));

   // R10
   done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (cs_n_o && !sck_o));

   if (SCK_HALF == 1) begin : g_sck_chk
      // R3
      sck_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (busy_o && $past(busy_o)) |-> (sck_o != $past(sck_o)));
   end

endmodule

// File: tb/test_sflash_read_seq.sv
module test_sflash_read_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       fast = 1'b0;
   logic [4:0] mode = '0;
   logic [31:0] addr = '0;
   logic [7:0] ops = 8'h03;
   logic [7:0] opd = 8'h3B;
   logic [7:0] opq = 8'h6B;
   logic [3:0] io_in = '0;
   logic       busy, cs_n, sck;
   logic [7:0] rd;
   logic [3:0] io_out, io_oe;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #10 clk = ~clk;

   sflash_read_seq i_sflash_read_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start),
      .fast_rd_i    (fast),
      .bus_mode_i   (mode),
      .addr_i       (addr),
      .opc_single_i (ops),
      .opc_dual_i   (opd),
      .opc_quad_i   (opq),
      .io_i         (io_in),
      .busy_o       (busy),
      .rd_data_o    (rd),
      .cs_n_o       (cs_n),
      .sck_o        (sck),
      .io_o         (io_out),
      .io_oe_o      (io_oe)
   );

   // flash model state (written only by the model process)
   int          rcount = 0;
   int          oe_err = 0;
   int          per_err = 0;
   int          cs_starts = 0;
   longint      clk_n = 0;
   longint      last_rise = 0;
   logic        sck_prev = 1'b0;
   logic        cs_prev = 1'b1;
   logic [7:0]  cap_op = '0;
   logic [31:0] cap_addr = '0;
   // expected shape, set by the bench before each launch
   int m_al = 1, m_dl = 1, m_acyc = 24, m_hdr = 32;

   function automatic logic [7:0] fbyte(logic [7:0] op, logic [31:0] a);
      return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ a[31:24] ^ op ^ 8'h96;
   endfunction

   function automatic logic [3:0] lmask(int l);
      return (l == 4) ? 4'b1111 : (l == 2) ? 4'b0011 : 4'b0001;
   endfunction

   always @(negedge clk) begin
      clk_n = clk_n + 1;
      if (!cs_n && cs_prev) begin
         rcount    = 0;
         cap_op    = '0;
         cap_addr  = '0;
         cs_starts = cs_starts + 1;
      end
      if (sck && !sck_prev) begin
         if (rcount > 0 && (clk_n - last_rise) != 2) per_err = per_err + 1;
         last_rise = clk_n;
         if (rcount < 8) begin
            if (io_oe !== 4'b0001) oe_err = oe_err + 1;
            cap_op = {cap_op[6:0], io_out[0]};
         end else if (rcount < 8 + m_acyc) begin
            if (io_oe !== lmask(m_al)) oe_err = oe_err + 1;
            case (m_al)
               2:       cap_addr = {cap_addr[29:0], io_out[1:0]};
               4:       cap_addr = {cap_addr[27:0], io_out};
               default: cap_addr = {cap_addr[30:0], io_out[0]};
            endcase
         end else begin
            if (io_oe !== 4'b0000) oe_err = oe_err + 1;
         end
         rcount = rcount + 1;
      end
      if (!sck && sck_prev && !cs_n) begin
         int j;
         logic [7:0] t;
         j = rcount - m_hdr;
         if (j >= 0 && j < 8 / m_dl) begin
            t = fbyte(cap_op, cap_addr) << (j * m_dl);
            case (m_dl)
               2:       io_in = {2'b00, t[7:6]};
               4:       io_in = t[7:4];
               default: io_in = {2'b00, t[7], 1'b0};
            endcase
         end
      end
      sck_prev = sck;
      cs_prev  = cs_n;
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // expected transaction shape from the mode arithmetic
   task automatic predict(input logic [4:0] m, input bit f, input logic [31:0] a,
                          output int al, output int dl, output int dmy, output int acyc,
                          output logic [7:0] op, output logic [31:0] ea, output bit illegal);
      logic [3:0] lo;
      lo = m[3:0];
      illegal = !(lo inside {4'b0000, 4'b0001, 4'b0011, 4'b0100, 4'b1100});
      if (illegal) lo = 4'b0000;
      dl  = lo[0] ? 2 : lo[2] ? 4 : 1;
      al  = lo[1] ? 2 : lo[3] ? 4 : 1;
      if (dl == 1)      dmy = f ? 8 : 0;
      else if (al == 1) dmy = 8;
      else if (al == 2) dmy = 4;
      else              dmy = 6;
      op   = (dl == 4) ? opq : (dl == 2) ? opd : ops;
      ea   = m[4] ? a : {8'h00, a[23:0]};
      acyc = (m[4] ? 32 : 24) / al;
   endtask

   task automatic wait_idle();
      int g;
      g = 0;
      while (busy && g < 4000) begin
         @(negedge clk);
         g++;
      end
      #1;
   endtask

   task automatic run(input logic [4:0] m, input bit f, input logic [31:0] a);
      int al, dl, dmy, acyc, oe0, pe0;
      logic [7:0] op;
      logic [31:0] ea;
      bit il;
      string rq;
      predict(m, f, a, al, dl, dmy, acyc, op, ea, il);
      m_al = al; m_dl = dl; m_acyc = acyc; m_hdr = 8 + acyc + dmy;
      oe0 = oe_err; pe0 = per_err;
      @(negedge clk);
      mode = m; fast = f; addr = a; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy === 1'b1 && cs_n === 1'b0, "R2 launch", {busy, cs_n}, 2'b10);
      wait_idle();
      rq = il ? "R11" : "R5";
      check(cap_op === op, rq, cap_op, op);
      check(cap_addr === ea, "R6 address", cap_addr, ea);
      check(rcount == m_hdr + 8 / dl, il ? "R11 cycles" : "R7 cycles", rcount, m_hdr + 8 / dl);
      check(oe_err == oe0, "R4 R8 enables", oe_err - oe0, 0);
      check(per_err == pe0, "R3 period", per_err - pe0, 0);
      check(rd === fbyte(op, ea), il ? "R11 data" : "R9 data", rd, fbyte(op, ea));
      check(cs_n === 1'b1 && sck === 1'b0, "R10 end", {cs_n, sck}, 2'b10);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(cs_n === 1'b1 && sck === 1'b0 && io_oe === 4'b0 && busy === 1'b0,
            "R1 reset", {cs_n, sck, busy, io_oe}, 7'b1000000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(cs_n === 1'b1 && sck === 1'b0 && io_oe === 4'b0 && busy === 1'b0,
            "R1 idle", {cs_n, sck, busy, io_oe}, 7'b1000000);

      // sweep every mode word with both fast-read settings
      for (int m = 0; m < 32; m++) begin
         for (int f = 0; f < 2; f++) begin
            run(5'(m), f[0], 32'hA5C3_1E97 ^ (32'(m) * 32'h0103_0507) ^ (32'(f) << 9));
         end
      end

      // R2: start while busy is ignored
      begin
         int al, dl, dmy, acyc, cs0;
         logic [7:0] op;
         logic [31:0] ea;
         bit il;
         predict(5'b11100, 1'b0, 32'h1234_5678, al, dl, dmy, acyc, op, ea, il);
         m_al = al; m_dl = dl; m_acyc = acyc; m_hdr = 8 + acyc + dmy;
         cs0 = cs_starts;
         @(negedge clk);
         mode = 5'b11100; fast = 1'b0; addr = 32'h1234_5678; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (20) @(negedge clk);
         mode = 5'b00000; fast = 1'b1; addr = 32'hFFFF_0000;
         opq = 8'hEB; ops = 8'h0B; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         check(busy === 1'b1, "R2 busy held", busy, 1);
         wait_idle();
         check(cap_op === op, "R2 opcode kept", cap_op, op);
         check(cap_addr === ea, "R2 address kept", cap_addr, ea);
         check(rcount == m_hdr + 8 / dl, "R2 length kept", rcount, m_hdr + 8 / dl);
         check(cs_starts == cs0 + 1, "R2 single select", cs_starts - cs0, 1);
         check(rd === fbyte(op, ea), "R2 data", rd, fbyte(op, ea));
         opq = 8'h6B; ops = 8'h03;
      end

      // R7: fast flag irrelevant to quad form, same count both ways
      run(5'b00100, 1'b1, 32'h0000_0010);
      run(5'b00011, 1'b1, 32'h00FF_FFFF);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule